// File: doc/BRIEF.md
# Tiled Matrix Corner-Turn Buffer

The block transposes a large square matrix that reaches it as a stream of square tiles. Each tile enters in row order and is stored in a local tile memory. It then leaves in column order, so the samples of every tile come out transposed. With the default parameters the matrix is 4096 × 4096 complex samples, cut into 64 × 64 tiles, which gives 4096 tiles per matrix. Each sample is a 64-bit word.

There are two tile banks, used in turn. One tile can be filled while the tile before it drains. Every outgoing tile carries the grid position of its source tile with row and column swapped. A downstream address generator uses that position to write the tile to its transposed place in external memory, which completes the corner-turn of the whole matrix. Both sides are valid/ready streams. The output side marks the last word of each tile and the last word of each matrix.

Top module: `corner_turn`

## Requirements
- R1: While reset is held and after it is released with no input, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Within a tile the input words are numbered w = r·D + c, where D is the tile side, r is the row and c is the column. Output word k of that tile equals input word w = (k mod D)·D + k div D. This is column order.
- R3: `out_last_o` is 1 on output word D²−1 of every tile and 0 on every other output word.
- R4: `out_frame_last_o` is 1 only on output word D²−1 of the tile with index T²−1 in a matrix, where T is the number of tiles per side. It is never 1 without `out_last_o`.
- R5: Input tiles are numbered t = 0 … T²−1 across a matrix. Tile t has source tile row t div T and source tile column t mod T. Each output tile shows `out_tile_row_o` = t mod T and `out_tile_col_o` = t div T. These values stay constant over the whole tile.
- R6: The block accepts a second complete tile while the first tile is still unread. When both banks hold tiles, `in_ready_o` is 0 until the oldest tile has fully left.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, the next cycle shows `out_valid_o` still at 1, with `out_data_o` and `out_last_o` unchanged.
- R8: Tiles leave in the order they arrived. The tile numbering wraps to 0 after tile T²−1, so consecutive matrices are handled the same way.
- R9: `in_last_i` must be 1 on input word D²−1 of each tile and only there. The block itself counts the tile boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Block can take an input word |
| in_data_i | input | DATA_W | Input sample, rows of a tile in order |
| in_last_i | input | 1 | Last word of the input tile |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the output word |
| out_data_o | output | DATA_W | Output sample, columns of a tile in order |
| out_last_o | output | 1 | Last word of the output tile |
| out_frame_last_o | output | 1 | Last word of the last tile of a matrix |
| out_tile_row_o | output | log2(T) | Destination tile row (source tile column) |
| out_tile_col_o | output | log2(T) | Destination tile column (source tile row) |

## Verification
The assertions check several properties on every cycle:
- output hold and data stability under back-pressure;
- that frame-last never appears without tile-last;
- that the tile position stays fixed within a tile;
- that input is refused while both banks are full;
- that the input tile-last marker lines up with the word count.

The transposed word order, the swapped tile coordinates and their wrap into a second matrix all depend on the data and its history, so only the bench's sweeps can show them. The bench compares every word of two complete small matrices, under steady and gapped traffic, against arithmetic expectations.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned CT_DATA_W_DEF     = 64;
  localparam int unsigned CT_TILE_DIM_DEF   = 64;
  localparam int unsigned CT_TILES_SIDE_DEF = 64;
  localparam int unsigned CT_NUM_BANKS      = 2;
endpackage

// File: rtl/ct_tile_mem.sv
module ct_tile_mem #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 4096,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ct_write_ctrl.sv
module ct_write_ctrl #(
  parameter int unsigned TILE_DIM   = 64,
  parameter int unsigned TILES_SIDE = 64,
  localparam int unsigned WORD_W = 2 * $clog2(TILE_DIM),
  localparam int unsigned TAG_W  = 2 * $clog2(TILES_SIDE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [1:0]        full_i,
  output logic              ready_o,
  output logic              we_o,
  output logic              done_o,
  output logic              bank_o,
  output logic [WORD_W-1:0] waddr_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam logic [WORD_W-1:0] WORD_MAX = '1;

  logic [WORD_W-1:0] wcnt_q;
  logic [TAG_W-1:0]  tile_q;
  logic              bank_q;

  assign ready_o = !full_i[bank_q];
  assign we_o    = valid_i && ready_o;
  assign done_o  = we_o && (wcnt_q == WORD_MAX);
  assign bank_o  = bank_q;
  assign waddr_o = wcnt_q;   // row-major fill
  assign tag_o   = tile_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      tile_q <= '0;
      bank_q <= 1'b0;
    end else if (we_o) begin
      wcnt_q <= wcnt_q + 1'b1;
      if (done_o) begin
        bank_q <= ~bank_q;
        tile_q <= tile_q + 1'b1;   // wraps after T*T-1
      end
    end
  end

  // R9: input tile-last marker must coincide with the final word
  a_r9_last_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |-> (last_i == (wcnt_q == WORD_MAX)));
endmodule

// File: rtl/ct_read_ctrl.sv
module ct_read_ctrl #(
  parameter int unsigned TILE_DIM = 64,
  localparam int unsigned LOG_D  = $clog2(TILE_DIM),
  localparam int unsigned WORD_W = 2 * LOG_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        full_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              last_o,
  output logic              release_o,
  output logic              bank_o,
  output logic [WORD_W-1:0] raddr_o
);
  localparam logic [WORD_W-1:0] WORD_MAX = '1;

  logic [WORD_W-1:0] rcnt_q, rcnt_d;
  logic              bank_q, prime_q, adv;

  assign valid_o   = full_i[bank_q] && prime_q;
  assign last_o    = (rcnt_q == WORD_MAX);
  assign adv       = valid_o && ready_i;
  assign release_o = adv && last_o;
  assign bank_o    = bank_q;

  always_comb begin
    rcnt_d = rcnt_q;
    if (adv) rcnt_d = last_o ? '0 : rcnt_q + 1'b1;
  end

  // counter runs column-major {col,row}; memory is row-major {row,col}
  assign raddr_o = {rcnt_d[LOG_D-1:0], rcnt_d[WORD_W-1:LOG_D]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q  <= '0;
      bank_q  <= 1'b0;
      prime_q <= 1'b0;
    end else begin
      rcnt_q <= rcnt_d;
      if (release_o) begin
        bank_q  <= ~bank_q;
        prime_q <= 1'b0;
      end else begin
        prime_q <= full_i[bank_q];   // one cycle for the first read to land
      end
    end
  end

  a_r7_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o);
endmodule

// File: rtl/corner_turn.sv
module corner_turn
  import ct_pkg::*;
#(
  parameter int unsigned DATA_W     = CT_DATA_W_DEF,
  parameter int unsigned TILE_DIM   = CT_TILE_DIM_DEF,
  parameter int unsigned TILES_SIDE = CT_TILES_SIDE_DEF,
  localparam int unsigned WORD_W = 2 * $clog2(TILE_DIM),
  localparam int unsigned TIDX_W = $clog2(TILES_SIDE),
  localparam int unsigned TAG_W  = 2 * TIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              out_frame_last_o,
  output logic [TIDX_W-1:0] out_tile_row_o,
  output logic [TIDX_W-1:0] out_tile_col_o
);
  localparam int unsigned      DEPTH   = TILE_DIM * TILE_DIM;
  localparam logic [TAG_W-1:0] TAG_MAX = '1;

  logic                          we, done, wbank, rd_release, rbank;
  logic [WORD_W-1:0]             waddr, raddr;
  logic [TAG_W-1:0]              wtag;
  logic [CT_NUM_BANKS-1:0]       full_q;
  logic [TAG_W-1:0]              tag_q   [CT_NUM_BANKS];
  logic [DATA_W-1:0]             rdata   [CT_NUM_BANKS];

  ct_write_ctrl #(.TILE_DIM(TILE_DIM), .TILES_SIDE(TILES_SIDE)) u_wr (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .last_i(in_last_i), .full_i(full_q),
    .ready_o(in_ready_o), .we_o(we), .done_o(done), .bank_o(wbank),
    .waddr_o(waddr), .tag_o(wtag)
  );

  ct_read_ctrl #(.TILE_DIM(TILE_DIM)) u_rd (
    .clk_i, .rst_ni,
    .full_i(full_q), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .last_o(out_last_o), .release_o(rd_release),
    .bank_o(rbank), .raddr_o(raddr)
  );

  for (genvar b = 0; b < CT_NUM_BANKS; b++) begin : g_bank
    ct_tile_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk_i,
      .we_i(we && (wbank == b[0])), .waddr_i(waddr), .wdata_i(in_data_i),
      .raddr_i(raddr), .rdata_o(rdata[b])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[b] <= 1'b0;
        tag_q[b]  <= '0;
      end else begin
        if (done && wbank == b[0]) begin
          full_q[b] <= 1'b1;
          tag_q[b]  <= wtag;
        end else if (rd_release && rbank == b[0]) begin
          full_q[b] <= 1'b0;
        end
      end
    end
  end

  assign out_data_o       = rdata[rbank];
  assign out_frame_last_o = out_valid_o && out_last_o && (tag_q[rbank] == TAG_MAX);
  // source row sits in the upper half of the tag; swap for destination
  assign out_tile_row_o   = tag_q[rbank][TIDX_W-1:0];
  assign out_tile_col_o   = tag_q[rbank][TAG_W-1:TIDX_W];

  a_r7_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> ($stable(out_data_o) && $stable(out_last_o)));

  a_r4_frame_has_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_frame_last_o |-> (out_last_o && out_valid_o));

  a_r5_tag_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o) |=>
      ($stable(out_tile_row_o) && $stable(out_tile_col_o)));

  a_r6_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&full_q) |-> !in_ready_o);
endmodule

// File: tb/corner_turn_bench.sv
`timescale 1ns/1ps
module corner_turn_bench;
  localparam int DW = 16;
  localparam int D  = 4;
  localparam int T  = 2;
  localparam int TW = D * D;          // words per tile
  localparam int FW = TW * T * T;     // words per matrix
  localparam int NF = 2;
  localparam int TOTAL = FW * NF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last, out_frame_last;
  logic [DW-1:0] out_data;
  logic [0:0] out_tile_row, out_tile_col;

  int checks = 0, errors = 0;
  int cyc = 0, g = 0, o = 0, phase = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  corner_turn #(.DATA_W(DW), .TILE_DIM(D), .TILES_SIDE(T)) u_corner_turn (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last), .out_frame_last_o(out_frame_last),
    .out_tile_row_o(out_tile_row), .out_tile_col_o(out_tile_col)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // producer: input word number g carries value g
  initial begin
    wait (rst_n);
    while (g < TOTAL) begin
      @(negedge clk);
      in_valid = (phase == 0) ? 1'b1 : (cyc % 7 != 6);
      in_data  = DW'(g);
      in_last  = (g % TW == TW - 1);
      if (in_valid && in_ready) g++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  end

  // consumer: checks every output word
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      out_ready = (phase == 0) ? 1'b0 : (cyc % 3 != 0);
      if (out_valid && out_ready && o < TOTAL) begin
        automatic int j = o / TW;
        automatic int k = o % TW;
        automatic int s = j % (T * T);
        automatic int src = j * TW + (k % D) * D + k / D;
        check(out_data == DW'(src), "R2 transposed word", int'(out_data), src);
        check(out_last == (k == TW - 1), "R3 tile last", int'(out_last), int'(k == TW - 1));
        check(out_frame_last == (k == TW - 1 && s == T * T - 1), "R4 frame last",
              int'(out_frame_last), int'(k == TW - 1 && s == T * T - 1));
        // R5 / R8: swapped coordinates, numbering wraps into second matrix
        check(int'(out_tile_row) == s % T, "R5 tile row", int'(out_tile_row), s % T);
        check(int'(out_tile_col) == s / T, "R8 tile col", int'(out_tile_col), s / T);
        o++;
      end
    end
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);

    // R6: output blocked, two tiles fill both banks then input stalls
    repeat (60) @(negedge clk);
    check(g == 2 * TW, "R6 words accepted", g, 2 * TW);
    check(in_ready == 1'b0, "R6 ready low when full", int'(in_ready), 0);

    // R7: held output while not ready
    check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
    held = out_data;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R7 valid still held", int'(out_valid), 1);
    check(out_data == held, "R7 data stable", int'(out_data), int'(held));
    check(out_data == '0, "R7 first word", int'(out_data), 0);

    phase = 1;
    while (o < TOTAL && cyc < 20000) @(negedge clk);
    check(cyc < 20000, "watchdog", cyc, 20000);
    check(o == TOTAL, "R8 all words out", o, TOTAL);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule